// File: doc/BRIEF.md
# Reflected Gray-Code Step Counter

This block is an N-bit counter whose registered state walks the reflected Gray sequence. It uses no binary adder, no binary shadow register and no code conversion. The counter is built by induction. The lower N-1 bits form a smaller Gray counter that can run forward or backward. The highest bit selects which way that smaller counter runs. The highest bit itself flips only when the smaller counter reaches the end of its sequence in the current direction. The same rule is applied at every level, down to one bit that simply toggles.

Each level needs only three facts to make its decision: whether its lower bits are all zeros, whether they are a one followed by zeros, and the value of its own top bit. The state steps once per clock edge while the enable input is high. A synchronous reset returns the state to zero.

Top module: `refl_gray_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `gray_q` becomes all zeros on that edge, whatever `en` is.
- R2: When `en` is low (and `rst` low) at a rising edge, `gray_q` keeps its value.
- R3: While the top bit of `gray_q` is 0, each enabled step advances the lower bits one position forward in their own Gray sequence.
- R4: When the top bit is 0 and the lower bits equal a 1 in their top position followed by zeros, the next enabled step sets the top bit to 1 and leaves the lower bits unchanged.
- R5: While the top bit is 1, each enabled step moves the lower bits one position backward in their own Gray sequence.
- R6: When the top bit is 1 and the lower bits are all zeros, the next enabled step clears the top bit and leaves the lower bits unchanged.
- R7: With a width of one, the single bit toggles on every enabled step.
- R8: Every enabled step changes exactly one bit of `gray_q`.
- R9: After k enabled steps from reset, `gray_q` equals (k mod 2^WIDTH) XOR ((k mod 2^WIDTH) >> 1), for every width from 1 to 8. From 1 followed by zeros, the state returns to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Step enable; one Gray step per edge while high |
| gray_q | output | WIDTH | Registered Gray-code state |

## Verification
Each result is due on the first rising edge after its stimulus, because the state register is the only register between the inputs and `gray_q`. The driver changes `en` and `rst` at the falling edge. At the same moment it queues the step count and the flags that the following rising edge must produce. The monitor samples a quarter period after that rising edge, takes the oldest queue entry and compares it with the 8-bit instance and with every narrower instance. That way, each comparison lines up with exactly one clock edge.

// File: rtl/rgc_pkg.sv
package rgc_pkg;

  // Direction in which a sub-counter walks its Gray sequence.
  typedef enum logic {
    RGC_DOWN = 1'b0,
    RGC_UP   = 1'b1
  } rgc_dir_e;

  // A set top bit mirrors the direction seen by the bits beneath it.
  function automatic rgc_dir_e rgc_reflect(rgc_dir_e dir, logic top);
    return rgc_dir_e'(dir ^ top);
  endfunction

endpackage

// File: rtl/rgc_end_detect.sv
module rgc_end_detect #(
  parameter int LOW_W = 1
) (
  input  logic [LOW_W-1:0] low,
  output logic             first_o,
  output logic             last_o
);

  // First state: all zeros.
  assign first_o = ~|low;

  // Last state: a one in the top position followed by zeros.
  generate
    if (LOW_W == 1) begin : g_one
      assign last_o = low[0];
    end else begin : g_many
      assign last_o = low[LOW_W-1] & ~|low[LOW_W-2:0];
    end
  endgenerate

endmodule

// File: rtl/rgc_level.sv
module rgc_level
  import rgc_pkg::*;
#(
  parameter int LOW_W = 1
) (
  input  logic [LOW_W-1:0] low,
  input  rgc_dir_e         low_dir,
  input  logic             act_in,
  output logic             act_out,
  output logic             flip_o
);

  logic first_s;
  logic last_s;
  logic at_end;

  rgc_end_detect #(.LOW_W(LOW_W)) u_end (
    .low    (low),
    .first_o(first_s),
    .last_o (last_s)
  );

  // The lower counter has nowhere to go in its current direction.
  assign at_end  = (low_dir == RGC_UP) ? last_s : first_s;

  // At the end this level's own bit flips; otherwise the step passes down.
  assign flip_o  = act_in & at_end;
  assign act_out = act_in & ~at_end;

endmodule

// File: rtl/refl_gray_counter.sv
module refl_gray_counter
  import rgc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [WIDTH-1:0] gray_q
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] act_v;
  logic [WIDTH-1:0] flip_v;

  // The whole counter always runs forward; the step enters at the top.
  assign act_v[TOP] = en;

  generate
    if (WIDTH > 1) begin : g_levels
      rgc_dir_e ldir [TOP:1];

      for (genvar k = TOP; k >= 1; k--) begin : g_lvl
        if (k == TOP) begin : g_head
          assign ldir[k] = rgc_reflect(RGC_UP, state_q[k]);
        end else begin : g_body
          assign ldir[k] = rgc_reflect(ldir[k+1], state_q[k]);
        end

        rgc_level #(.LOW_W(k)) u_level (
          .low    (state_q[k-1:0]),
          .low_dir(ldir[k]),
          .act_in (act_v[k]),
          .act_out(act_v[k-1]),
          .flip_o (flip_v[k])
        );
      end
    end
  endgenerate

  // Base case: the lowest bit toggles whenever a step reaches it.
  assign flip_v[0] = act_v[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
    end else begin
      state_q <= state_q ^ flip_v;
    end
  end

  assign gray_q = state_q;

endmodule

// File: rtl/refl_gray_counter_chk.sv
module refl_gray_counter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [WIDTH-1:0] gray_q
);

  localparam logic [WIDTH-1:0] MAXV = WIDTH'(1) << (WIDTH - 1);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (gray_q == '0)); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(gray_q)); // R2

  AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
    en |=> ($countones(gray_q ^ $past(gray_q)) == 1)); // R8

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (en && gray_q == MAXV) |=> (gray_q == '0)); // R9

  generate
    if (WIDTH > 1) begin : g_top
      localparam int LW = WIDTH - 1;
      localparam logic [LW-1:0] LEAD = LW'(1) << (LW - 1);

      AST_TOP_RISES: assert property (@(posedge clk) disable iff (rst)
        (en && !gray_q[LW] && gray_q[LW-1:0] == LEAD)
        |=> (gray_q[LW] && $stable(gray_q[LW-1:0]))); // R4

      AST_TOP_FALLS: assert property (@(posedge clk) disable iff (rst)
        (en && gray_q[LW] && gray_q[LW-1:0] == '0)
        |=> (!gray_q[LW] && gray_q[LW-1:0] == '0)); // R6
    end
  endgenerate

endmodule

bind refl_gray_counter refl_gray_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .en    (en),
  .gray_q(gray_q)
);

// File: tb/test_refl_gray_counter.sv
module test_refl_gray_counter;

  localparam int CLK_P = 10;
  localparam int MAXW  = 8;

  typedef struct {
    int k;
    bit en;
    bit rs;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [MAXW-1:0] main_q;
  logic [MAXW-1:0][MAXW-1:0] small_q;

  item_t exp_q[$];
  int    k_cnt  = 0;
  int    checks = 0;
  int    fails  = 0;
  logic [MAXW-1:0] prev_main = '0;

  always #(CLK_P/2) clk = ~clk;

  refl_gray_counter #(.WIDTH(MAXW)) i_refl_gray_counter (
    .clk(clk), .rst(rst), .en(en), .gray_q(main_q)
  );

  assign small_q[0] = '0;
  for (genvar w = 1; w < MAXW; w++) begin : g_w
    logic [w-1:0] o;
    refl_gray_counter #(.WIDTH(w)) u_w (
      .clk(clk), .rst(rst), .en(en), .gray_q(o)
    );
    assign small_q[w] = {{(MAXW-w){1'b0}}, o};
  end

  function automatic logic [MAXW-1:0] gray_of(int k, int w);
    int m = k & ((1 << w) - 1);
    return MAXW'(m ^ (m >> 1));
  endfunction

  task automatic check(string tag, int w, logic [MAXW-1:0] act, logic [MAXW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s width %0d: got %h expected %h", tag, w, act, exp);
    end
  endtask

  // Driver: sets inputs at the falling edge and queues what the next edge owes.
  task automatic drive(bit e);
    item_t it;
    @(negedge clk);
    en = e;
    if (e) k_cnt++;
    it.k = k_cnt; it.en = e; it.rs = 1'b0;
    exp_q.push_back(it);
  endtask

  task automatic pulse_reset();
    item_t it;
    @(negedge clk);
    rst = 1'b1; en = 1'b1; k_cnt = 0;
    it.k = 0; it.en = 1'b1; it.rs = 1'b1;
    exp_q.push_back(it);
    @(negedge clk);
    rst = 1'b0; en = 1'b0;
    it.k = 0; it.en = 1'b0; it.rs = 1'b0;
    exp_q.push_back(it);
  endtask

  // Monitor: compares a quarter period after each rising edge.
  always @(posedge clk) begin
    #(CLK_P/4);
    if (exp_q.size() > 0) begin
      item_t it;
      logic [MAXW-1:0] exp_m;
      string tag;
      it = exp_q.pop_front();
      exp_m = gray_of(it.k, MAXW);
      if (it.rs) tag = "R1";
      else if (!it.en) tag = "R2";
      else if (!prev_main[MAXW-1] && main_q[MAXW-1] != prev_main[MAXW-1]) tag = "R4";
      else if (prev_main[MAXW-1] && main_q[MAXW-1] != prev_main[MAXW-1]) tag = "R6";
      else if (!prev_main[MAXW-1]) tag = "R3";
      else tag = "R5";
      check(tag, MAXW, main_q, exp_m);
      if (it.en && !it.rs) begin
        checks++;
        if ($countones(main_q ^ prev_main) != 1) begin
          fails++;
          $display("FAIL R8 width %0d: changed bits %0d expected 1",
                   MAXW, $countones(main_q ^ prev_main));
        end
      end
      check(it.rs ? "R1" : "R7", 1, small_q[1], gray_of(it.k, 1));
      for (int w = 2; w < MAXW; w++) begin
        check(it.rs ? "R1" : "R9", w, small_q[w], gray_of(it.k, w));
      end
      prev_main = main_q;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", MAXW, main_q, '0);
    rst = 1'b0; en = 1'b0;
    for (int i = 0; i < 5; i++) drive(1'b1);
    for (int i = 0; i < 3; i++) drive(1'b0);
    for (int i = 0; i < 700; i++) drive((i % 7) != 3);
    pulse_reset();
    for (int i = 0; i < 300; i++) drive(1'b1);
    drive(1'b0);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule